// File: doc/BRIEF.md
# Sector Buffer Host Transfer Engine

This block moves data out of a byte-wide sector buffer toward a host. Software programs a 16-bit byte count and a 16-bit buffer address through a small register port, enables transfers in a control register and then writes a trigger. From then on the data leaves by one of two paths. The first is single big-endian word reads issued by a main or a sub host. The second is burst DMA, one word per clock, into a program memory or a word memory that has a banked and an unbanked layout.

Completion can come from either path. It clears the internal busy flag and sets an end flag. It also sets an active-low busy bit in an 8-bit status byte. When enabled, it clears an active-low end-interrupt bit and pulses a level-5 interrupt request. An acknowledge write re-arms the end-interrupt bit. The sector buffer and the destination memories sit outside the block.

Top module: `sbx_xfer`

## Requirements
- R1: After reset the byte count, buffer address and DMA address are 0. Busy, end flag and irq are low, the status byte reads 0xFF and host_rdata is 0.
- R2: Register selects on reg_sel are 0 control, 1 count low byte, 2 count high byte, 3 address low byte, 4 address high byte, 5 trigger and 6 acknowledge. In the control byte, bit 1 enables transfers and bit 6 enables the end interrupt. A trigger write starts a transfer only while the enable bit is set. Starting sets busy, clears the end flag and clears status bit 3.
- R3: A control write with bit 1 clear aborts. It zeroes the byte count, clears busy, sets status bit 3 and stops any burst in progress.
- R4: A host read is accepted only while busy, while no burst runs, and while dest_sel is 2 (main host, host_sub=0) or 3 (sub host, host_sub=1). Any other read returns 0 on host_rdata and changes neither the count nor the address.
- R5: An accepted read returns {buf[a], buf[a+1]} one cycle later, where a is the buffer address. The address then advances by 2, wrapping at 16 bits, and the count drops by 2.
- R6: An accepted read made while the count is 2 or less completes the transfer. The count is clamped to 0, busy clears, the end flag sets and status bit 3 sets.
- R7: At completion with control bit 6 set, status bit 6 clears. If irq_mask is also high, irq is high for exactly one cycle.
- R8: An acknowledge write sets status bit 6.
- R9: dma_start is accepted while busy, with no burst running and dest_sel 5 (program memory) or 7 (word memory). Above 512 bytes a burst is 256 words. At or below 512 bytes it is (count+1)/2 words, and the transfer completes in the start cycle. Each word is written one per clock.
- R10: After each burst the buffer address has advanced 2 per word, wrapping at 16 bits. The count has dropped by 512, or is 0 after the final burst. The DMA address has advanced by the word count divided by 4.
- R11: The destination byte address of word i is base+2i. For dest 5 the base is the DMA address times 8. For dest 7 with bank_mode set it is (DMA address mod 2^14) times 8, and dma_bank carries bank_sel. With bank_mode clear it is (DMA address mod 2^15) times 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| dest_sel | input | 3 | Destination field of the mode register |
| irq_mask | input | 1 | Level-5 interrupt mask bit |
| bank_mode | input | 1 | Word memory banked layout |
| bank_sel | input | 1 | Word memory bank for banked layout |
| dma_adr_we | input | 1 | DMA address load strobe |
| dma_adr_wdata | input | 16 | DMA address load value |
| dma_start | input | 1 | Burst request |
| host_rd | input | 1 | Host word read strobe |
| host_sub | input | 1 | Read issued by the sub host |
| buf_addr | output | 16 | Buffer address of the high byte |
| buf_addr_nxt | output | 16 | Buffer address of the low byte |
| buf_byte0 | input | 8 | Buffer byte at buf_addr |
| buf_byte1 | input | 8 | Buffer byte at buf_addr_nxt |
| host_rdata | output | 16 | Host read data |
| dma_we | output | 1 | Destination write strobe |
| dma_dest | output | 3 | Destination code of the burst |
| dma_bank | output | 1 | Word memory bank of the write |
| dma_waddr | output | 19 | Destination byte address |
| dma_wdata | output | 16 | Destination write data |
| byte_count | output | 16 | Remaining byte count |
| dma_adr | output | 16 | DMA address register |
| busy | output | 1 | Transfer in progress |
| end_flag | output | 1 | Transfer ended flag |
| if_status | output | 8 | Status byte, bit 3 busy low, bit 6 end interrupt low |
| irq | output | 1 | Level-5 interrupt pulse |

## Verification
Host reads are tried with even and odd counts. The odd count separates a clamp to zero from a simple subtraction. Reads also go out with a wrong host, an idle engine and a burst running, which separates the three acceptance conditions. DMA runs with a count of several full bursts and a buffer address near 0xFFFF, which exposes wrong burst lengths, a missed wrap or a wrong DMA address step. Banked and unbanked word memory runs with a DMA address carrying high bits show whether the right mask is applied. An abort and a trigger while disabled round out the control paths.

// File: rtl/sbx_pkg.sv
package sbx_pkg;
  typedef enum logic [2:0] {
    SEL_CTRL   = 3'd0,
    SEL_CNT_LO = 3'd1,
    SEL_CNT_HI = 3'd2,
    SEL_ADR_LO = 3'd3,
    SEL_ADR_HI = 3'd4,
    SEL_TRIG   = 3'd5,
    SEL_ACK    = 3'd6,
    SEL_NONE   = 3'd7
  } reg_sel_e;

  localparam logic [2:0] DEST_MAIN = 3'd2;
  localparam logic [2:0] DEST_SUB  = 3'd3;
  localparam logic [2:0] DEST_PRG  = 3'd5;
  localparam logic [2:0] DEST_WORD = 3'd7;

  localparam int CTRL_EN_BIT  = 1;
  localparam int CTRL_IE_BIT  = 6;
  localparam int STAT_BUSY_N  = 3;
  localparam int STAT_ENDI_N  = 6;
endpackage

// File: rtl/sbx_burst.sv
module sbx_burst #(
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             abort,
  input  logic [LEN_W-1:0] len,
  output logic             active,
  output logic             last,
  output logic [LEN_W-1:0] idx
);
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      idx    <= '0;
      len_q  <= '0;
    end else if (abort) begin
      active <= 1'b0;
    end else if (start && len != '0) begin
      active <= 1'b1;
      idx    <= '0;
      len_q  <= len;
    end else if (active) begin
      if (last) active <= 1'b0;
      else      idx    <= idx + 1'b1;
    end
  end

  assign last = active && (idx == len_q - 1'b1);

  // R9: the word index never runs past the burst length
  a_r9_idx_in_range: assert property (@(posedge clk) disable iff (rst)
    active |-> (idx < len_q));
endmodule

// File: rtl/sbx_status.sv
module sbx_status (
  input  logic       clk,
  input  logic       rst,
  input  logic       ev_start,
  input  logic       ev_idle,
  input  logic       ev_end_irq,
  input  logic       ev_ack,
  output logic [7:0] status
);
  import sbx_pkg::*;
  logic busy_n_q, endi_n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_n_q <= 1'b1;
      endi_n_q <= 1'b1;
    end else begin
      if (ev_start)   busy_n_q <= 1'b0;
      if (ev_idle)    busy_n_q <= 1'b1;
      if (ev_ack)     endi_n_q <= 1'b1;
      if (ev_end_irq) endi_n_q <= 1'b0;
    end
  end

  always_comb begin
    status = 8'hFF;
    status[STAT_BUSY_N] = busy_n_q;
    status[STAT_ENDI_N] = endi_n_q;
  end

  // R8: an acknowledge with no completion in the same cycle re-arms bit 6
  a_r8_ack_sets: assert property (@(posedge clk) disable iff (rst)
    (ev_ack && !ev_end_irq) |=> status[STAT_ENDI_N]);
endmodule

// File: rtl/sbx_xfer.sv
module sbx_xfer #(
  parameter int CNT_W       = 16,
  parameter int BUF_AW      = 16,
  parameter int DMA_AW      = 16,
  parameter int BURST_WORDS = 256,
  parameter int WBANK_BITS  = 14,
  parameter int WFLAT_BITS  = 15,
  parameter int DST_AW      = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [7:0]        reg_wdata,
  input  logic [2:0]        dest_sel,
  input  logic              irq_mask,
  input  logic              bank_mode,
  input  logic              bank_sel,
  input  logic              dma_adr_we,
  input  logic [DMA_AW-1:0] dma_adr_wdata,
  input  logic              dma_start,
  input  logic              host_rd,
  input  logic              host_sub,
  output logic [BUF_AW-1:0] buf_addr,
  output logic [BUF_AW-1:0] buf_addr_nxt,
  input  logic [7:0]        buf_byte0,
  input  logic [7:0]        buf_byte1,
  output logic [15:0]       host_rdata,
  output logic              dma_we,
  output logic [2:0]        dma_dest,
  output logic              dma_bank,
  output logic [DST_AW-1:0] dma_waddr,
  output logic [15:0]       dma_wdata,
  output logic [CNT_W-1:0]  byte_count,
  output logic [DMA_AW-1:0] dma_adr,
  output logic              busy,
  output logic              end_flag,
  output logic [7:0]        if_status,
  output logic              irq
);
  import sbx_pkg::*;

  localparam int LEN_W       = $clog2(BURST_WORDS) + 1;
  localparam int BURST_BYTES = 2 * BURST_WORDS;

  reg_sel_e          sel;
  logic [CNT_W-1:0]  cnt_q;
  logic [BUF_AW-1:0] dac_q;
  logic              ctrl_en_q, ctrl_ie_q, busy_q, end_q, irq_q, fin_q;
  logic [LEN_W-1:0]  blen_q, blen_nx, b_idx;
  logic [CNT_W:0]    half_cnt;
  logic [DST_AW-1:0] base_q, base_nx;
  logic              b_active, b_last;
  logic              ctrl_wr, abort, trig, ack, dest_ok, rd_ok, rd_done;
  logic              dma_ok, cnt_fin, complete;

  assign sel      = reg_sel_e'(reg_sel);
  assign ctrl_wr  = reg_we && sel == SEL_CTRL;
  assign abort    = ctrl_wr && !reg_wdata[CTRL_EN_BIT];
  assign trig     = reg_we && sel == SEL_TRIG && ctrl_en_q;
  assign ack      = reg_we && sel == SEL_ACK;
  assign dest_ok  = host_sub ? (dest_sel == DEST_SUB) : (dest_sel == DEST_MAIN);
  assign rd_ok    = host_rd && busy_q && !b_active && dest_ok;
  assign rd_done  = rd_ok && (cnt_q <= CNT_W'(2));
  assign cnt_fin  = cnt_q <= CNT_W'(BURST_BYTES);
  assign dma_ok   = dma_start && busy_q && !b_active &&
                    (dest_sel == DEST_PRG || dest_sel == DEST_WORD);
  assign complete = rd_done || (dma_ok && cnt_fin);
  assign half_cnt = ({1'b0, cnt_q} + 1'b1) >> 1;
  assign blen_nx  = cnt_fin ? LEN_W'(half_cnt) : LEN_W'(BURST_WORDS);

  always_comb begin
    if (dest_sel == DEST_WORD) begin
      if (bank_mode) base_nx = DST_AW'({dma_adr[WBANK_BITS-1:0], 3'b000});
      else           base_nx = DST_AW'({dma_adr[WFLAT_BITS-1:0], 3'b000});
    end else begin
      base_nx = DST_AW'({dma_adr, 3'b000});
    end
  end

  sbx_burst #(.LEN_W(LEN_W)) u_burst (
    .clk(clk), .rst(rst), .start(dma_ok), .abort(abort), .len(blen_nx),
    .active(b_active), .last(b_last), .idx(b_idx)
  );

  sbx_status u_status (
    .clk(clk), .rst(rst), .ev_start(trig), .ev_idle(abort || complete),
    .ev_end_irq(complete && ctrl_ie_q), .ev_ack(ack), .status(if_status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0; dac_q <= '0; dma_adr <= '0;
      ctrl_en_q <= 1'b0; ctrl_ie_q <= 1'b0;
      busy_q <= 1'b0; end_q <= 1'b0; irq_q <= 1'b0; fin_q <= 1'b0;
      blen_q <= '0; base_q <= '0; host_rdata <= '0;
      dma_we <= 1'b0; dma_dest <= '0; dma_bank <= 1'b0;
      dma_waddr <= '0; dma_wdata <= '0;
    end else begin
      irq_q  <= 1'b0;
      dma_we <= 1'b0;
      if (reg_we) begin
        case (sel)
          SEL_CTRL:   begin
                        ctrl_en_q <= reg_wdata[CTRL_EN_BIT];
                        ctrl_ie_q <= reg_wdata[CTRL_IE_BIT];
                      end
          SEL_CNT_LO: cnt_q[7:0]        <= reg_wdata;
          SEL_CNT_HI: cnt_q[CNT_W-1:8]  <= reg_wdata[CNT_W-9:0];
          SEL_ADR_LO: dac_q[7:0]        <= reg_wdata;
          SEL_ADR_HI: dac_q[BUF_AW-1:8] <= reg_wdata[BUF_AW-9:0];
          default: ;
        endcase
      end
      if (abort) begin
        cnt_q  <= '0;
        busy_q <= 1'b0;
      end
      if (trig) begin
        busy_q <= 1'b1;
        end_q  <= 1'b0;
      end
      if (host_rd) host_rdata <= rd_ok ? {buf_byte0, buf_byte1} : 16'h0000;
      if (rd_ok) begin
        dac_q <= dac_q + BUF_AW'(2);
        cnt_q <= rd_done ? '0 : cnt_q - CNT_W'(2);
      end
      if (complete) begin
        busy_q <= 1'b0;
        end_q  <= 1'b1;
        irq_q  <= ctrl_ie_q && irq_mask;
      end
      if (dma_ok) begin
        blen_q   <= blen_nx;
        fin_q    <= cnt_fin;
        base_q   <= base_nx;
        dma_dest <= dest_sel;
        dma_bank <= (dest_sel == DEST_WORD) && bank_mode && bank_sel;
      end
      if (b_active && !abort) begin
        dma_we    <= 1'b1;
        dma_waddr <= base_q + DST_AW'({b_idx, 1'b0});
        dma_wdata <= {buf_byte0, buf_byte1};
        dac_q     <= dac_q + BUF_AW'(2);
        if (b_last) begin
          cnt_q   <= fin_q ? '0 : cnt_q - CNT_W'(BURST_BYTES);
          dma_adr <= dma_adr + DMA_AW'(blen_q >> 2);
        end
      end
      if (dma_adr_we) dma_adr <= dma_adr_wdata;
    end
  end

  assign buf_addr     = dac_q;
  assign buf_addr_nxt = dac_q + BUF_AW'(1);
  assign byte_count   = cnt_q;
  assign busy         = busy_q;
  assign end_flag     = end_q;
  assign irq          = irq_q;

  // R2: internal busy and the active-low status bit always agree
  a_r2_busy_matches_status: assert property (@(posedge clk) disable iff (rst)
    busy_q == !if_status[STAT_BUSY_N]);
  // R7: an interrupt pulse only accompanies an ended transfer with bit 6 low
  a_r7_irq_with_end: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (end_q && !if_status[STAT_ENDI_N]));
  // R3: an abort leaves count zero and the engine idle
  a_r3_abort_idle: assert property (@(posedge clk) disable iff (rst)
    (abort && !trig) |=> (cnt_q == '0 && !busy_q));
  // R5: a non-final accepted read removes exactly two bytes
  a_r5_count_step: assert property (@(posedge clk) disable iff (rst)
    (rd_ok && !rd_done && !reg_we) |=> (cnt_q == $past(cnt_q) - CNT_W'(2)));
  // R11: destination writes only target program or word memory
  a_r11_dest_valid: assert property (@(posedge clk) disable iff (rst)
    dma_we |-> (dma_dest == DEST_PRG || dma_dest == DEST_WORD));
endmodule

// File: tb/tb_sbx_xfer.sv
module tb_sbx_xfer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_we = 0, irq_mask = 0, bank_mode = 0, bank_sel = 0;
  logic dma_adr_we = 0, dma_start = 0, host_rd = 0, host_sub = 0;
  logic [2:0] reg_sel = 0, dest_sel = 0;
  logic [7:0] reg_wdata = 0;
  logic [15:0] dma_adr_wdata = 0;
  logic [15:0] buf_addr, buf_addr_nxt, host_rdata, dma_wdata, byte_count, dma_adr;
  logic [7:0] buf_byte0, buf_byte1, if_status;
  logic dma_we, dma_bank, busy, end_flag, irq;
  logic [2:0] dma_dest;
  logic [18:0] dma_waddr;

  logic [7:0] bmem [0:4095];
  logic [15:0] got_mem [int];
  logic [15:0] exp_mem [int];
  int nchk = 0, nerr = 0, got_writes = 0, exp_writes = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign buf_byte0 = bmem[buf_addr[11:0]];
  assign buf_byte1 = bmem[buf_addr_nxt[11:0]];

  sbx_xfer dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .dest_sel(dest_sel), .irq_mask(irq_mask), .bank_mode(bank_mode), .bank_sel(bank_sel),
    .dma_adr_we(dma_adr_we), .dma_adr_wdata(dma_adr_wdata), .dma_start(dma_start),
    .host_rd(host_rd), .host_sub(host_sub), .buf_addr(buf_addr), .buf_addr_nxt(buf_addr_nxt),
    .buf_byte0(buf_byte0), .buf_byte1(buf_byte1), .host_rdata(host_rdata),
    .dma_we(dma_we), .dma_dest(dma_dest), .dma_bank(dma_bank), .dma_waddr(dma_waddr),
    .dma_wdata(dma_wdata), .byte_count(byte_count), .dma_adr(dma_adr), .busy(busy),
    .end_flag(end_flag), .if_status(if_status), .irq(irq)
  );

  // behavioural reference model
  int m_cnt, m_dac, m_dadr, m_left, m_blen, m_base, m_idx, m_dq, m_rdata;
  bit m_en, m_ie, m_busy, m_end, m_bn, m_endn, m_irq, m_fin, m_bank;

  function automatic int word_at(int a);
    return {bmem[a & 12'hFFF], bmem[(a + 1) & 12'hFFF]};
  endfunction

  function automatic int mkey(int d, int b, int a);
    return d * (1 << 24) + b * (1 << 20) + a;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_dac = 0; m_dadr = 0; m_left = 0; m_blen = 0; m_base = 0;
      m_idx = 0; m_dq = 0; m_rdata = 0; m_en = 0; m_ie = 0; m_busy = 0;
      m_end = 0; m_bn = 1; m_endn = 1; m_irq = 0; m_fin = 0; m_bank = 0;
    end else begin
      bit on, done;
      on = m_left > 0; done = 0; m_irq = 0;
      if (reg_we) begin
        case (reg_sel)
          3'd0: begin m_en = reg_wdata[1]; m_ie = reg_wdata[6];
                  if (!reg_wdata[1]) begin m_cnt = 0; m_busy = 0; m_bn = 1; m_left = 0; on = 0; end end
          3'd1: m_cnt = (m_cnt & 16'hFF00) | reg_wdata;
          3'd2: m_cnt = (m_cnt & 16'h00FF) | (reg_wdata << 8);
          3'd3: m_dac = (m_dac & 16'hFF00) | reg_wdata;
          3'd4: m_dac = (m_dac & 16'h00FF) | (reg_wdata << 8);
          3'd5: if (m_en) begin m_busy = 1; m_end = 0; m_bn = 0; end
          3'd6: m_endn = 1;
          default: ;
        endcase
      end
      if (host_rd) begin
        if (m_busy && !on && dest_sel == (host_sub ? 3'd3 : 3'd2)) begin
          m_rdata = word_at(m_dac); m_dac = (m_dac + 2) & 16'hFFFF;
          if (m_cnt <= 2) begin m_cnt = 0; done = 1; end else m_cnt = m_cnt - 2;
        end else m_rdata = 0;
      end
      if (dma_start && m_busy && !on && (dest_sel == 3'd5 || dest_sel == 3'd7)) begin
        m_dq = dest_sel; m_bank = (dest_sel == 3'd7) && bank_mode && bank_sel;
        if (dest_sel == 3'd5) m_base = m_dadr * 8;
        else if (bank_mode)   m_base = (m_dadr & 16'h3FFF) * 8;
        else                  m_base = (m_dadr & 16'h7FFF) * 8;
        if (m_cnt <= 512) begin m_blen = (m_cnt + 1) / 2; m_fin = 1; done = 1; end
        else begin m_blen = 256; m_fin = 0; end
        m_left = m_blen; m_idx = 0;
      end
      if (on) begin
        exp_mem[mkey(m_dq, m_bank, m_base + 2 * m_idx)] = 16'(word_at(m_dac));
        exp_writes++;
        m_dac = (m_dac + 2) & 16'hFFFF; m_idx++; m_left--;
        if (m_left == 0) begin
          m_cnt = m_fin ? 0 : m_cnt - 512;
          m_dadr = (m_dadr + m_blen / 4) & 16'hFFFF;
        end
      end
      if (dma_adr_we) m_dadr = dma_adr_wdata;
      if (done) begin
        m_busy = 0; m_end = 1; m_bn = 1;
        if (m_ie) begin m_endn = 0; m_irq = irq_mask; end
      end
    end
  end

  task automatic chk(string tag, int got, int exp);
    nchk++;
    if (got != exp) begin
      nerr++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    if (dma_we) begin
      got_mem[mkey(dma_dest, dma_bank, dma_waddr)] = dma_wdata;
      got_writes++;
    end
    if (!rst) begin
      chk("R6 byte_count", byte_count, m_cnt);
      chk("R5 buf_addr", buf_addr, m_dac);
      chk("R2 busy", busy, m_busy);
      chk("R6 end_flag", end_flag, m_end);
      chk("R3 if_status", if_status, 8'hFF & ~(m_bn ? 0 : 8) & ~(m_endn ? 0 : 8'h40));
      chk("R7 irq", irq, m_irq);
      chk("R4 host_rdata", host_rdata, m_rdata);
      chk("R10 dma_adr", dma_adr, m_dadr);
    end
  endtask

  // R2: register select encoding 0..6
  task automatic wr(int s, int d);
    reg_we = 1; reg_sel = 3'(s); reg_wdata = 8'(d); tick(); reg_we = 0;
  endtask
  task automatic rd(bit sub);
    host_rd = 1; host_sub = sub; tick(); host_rd = 0;
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask
  task automatic dstart();
    dma_start = 1; tick(); dma_start = 0;
  endtask
  task automatic setup(int cnt, int adr);
    wr(1, cnt & 8'hFF); wr(2, cnt >> 8); wr(3, adr & 8'hFF); wr(4, adr >> 8);
  endtask
  task automatic load_dadr(int v);
    dma_adr_we = 1; dma_adr_wdata = 16'(v); tick(); dma_adr_we = 0;
  endtask

  bit finished = 0;
  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) bmem[i] = 8'((i * 7 + 3) ^ (i >> 8));
    idle(3); rst = 0;
    // R1: reset state
    chk("R1 count", byte_count, 0); chk("R1 status", if_status, 8'hFF);
    chk("R1 busy", busy, 0); chk("R1 end", end_flag, 0); chk("R1 irq", irq, 0);
    chk("R1 dma_adr", dma_adr, 0); chk("R1 rdata", host_rdata, 0);
    tick();
    // R2: trigger while disabled is ignored
    setup(6, 16'h0010); wr(5, 0); idle(2);
    // R4/R5/R6/R7: sub host reads, wrong host rejected
    irq_mask = 1; dest_sel = 3'd3; wr(0, 8'h42); wr(5, 0);
    rd(0); rd(1); rd(1); rd(1); idle(2);
    rd(1); // R4 idle engine
    wr(6, 0); // R8 acknowledge
    chk("R8 status bit6", if_status[6], 1);
    // odd count, main host, irq enable off
    dest_sel = 3'd2; wr(0, 8'h02); setup(5, 16'hFFFE); wr(5, 0);
    rd(0); rd(0); rd(0); idle(2);
    // R3: abort mid transfer
    setup(40, 16'h0100); wr(5, 0); rd(0); wr(0, 8'h00); idle(2); rd(0);
    // R9/R10/R11: program memory, several bursts, address wrap
    wr(0, 8'h42); dest_sel = 3'd5; load_dadr(16'h0010); setup(1200, 16'hFFF0); wr(5, 0);
    for (int b = 0; b < 4; b++) begin dstart(); idle(262); end
    wr(6, 0);
    // R11: banked word memory
    dest_sel = 3'd7; bank_mode = 1; bank_sel = 1; load_dadr(16'h4005);
    setup(9, 16'h0200); wr(5, 0); dstart(); idle(10);
    // R11: unbanked, host read during a burst rejected (R4)
    bank_mode = 0; load_dadr(16'h9003); setup(600, 16'h0400); wr(5, 0);
    dstart(); idle(10); dest_sel = 3'd2; rd(0); dest_sel = 3'd7; idle(250);
    dstart(); idle(50);
    // R9: number of destination writes
    chk("R9 write count", got_writes, exp_writes);
    chk("R11 entries", got_mem.size(), exp_mem.size());
    foreach (exp_mem[k]) begin
      if (got_mem.exists(k)) chk("R11 dest word", got_mem[k], exp_mem[k]);
      else chk("R11 dest missing", 0, 1);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule